// File: doc/BRIEF.md
# DMA Channel Interrupt Status

This block holds the interrupt enables and the event status bits of one DMA channel. The channel engine sends it one-cycle pulses for six events: the whole block finished, the final frame started, a frame finished, half of a frame finished, a synchronization event was dropped, and a timeout occurred. An event is recorded in status only while its enable is set. Any recorded event raises the channel interrupt request.

Software reaches the enables and the status through a small synchronous register port. A read of status returns the current bits and clears the event bits. An event that arrives in the same cycle as that read is kept. Status bit 6 shows the engine's synchronization-pending input directly and never raises the interrupt.

Top module: `dma_chan_irq`

## Requirements
- R1: After reset the enable register reads 0x0003 (drop and timeout enabled), the status register reads 0x0000 with the sync input low, and irq_o is 0.
- R2: A write to the enable register (address 0) stores wdata_i[5:0]. Bits 15 to 6 always read as 0.
- R3: An event pulse on evt_i[k] while enable bit k is 1 sets status bit k at the next clock edge and raises irq_o. The bit positions are block=5, last=4, frame=3, half=2, drop=1 and timeout=0, the same in evt_i, the enable register and status.
- R4: An event pulse while its enable bit is 0 leaves its status bit unchanged and does not raise irq_o.
- R5: A read of status (address 1) returns the bits as they stood before the read. Status bits 5 to 0 are 0 after that edge.
- R6: An enabled event in the same cycle as a clearing status read is not returned by that read, and its bit stays set afterwards.
- R7: irq_o is the OR of status bits 5 to 0. It stays high until those bits are cleared by a status read.
- R8: Clearing an enable bit does not clear a status bit that is already set.
- R9: Writes to the status register have no effect.
- R10: Status bit 6 reflects sync_pend_i at the time of the read. A status read does not clear it, and it never drives irq_o.
- R11: rdata_o is registered. It shows the value addressed in the cycle where re_i is high after the next clock edge, and it holds until the next read. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 6 | One-cycle event pulses from the channel engine |
| sync_pend_i | input | 1 | Synchronization event pending |
| addr_i | input | 2 | Register address: 0 = enable, 1 = status |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| irq_o | output | 1 | Channel interrupt request |

## Verification
On every cycle, the assertions check four things for each status bit: an enabled event sets the bit, a disabled event never sets a clear bit, a set bit is kept until a clearing read, and a clearing read with no coincident event empties the bit. They also check that irq_o stays high while no read clears it, and that the enables change only on a write. The bench scenarios are needed to show the register encoding through the read port: the reset values, the reserved bits reading 0, the returned data of a clearing read when an event arrives in the same cycle, the sync mirror, and that writes to status do nothing.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W   = 16;
  localparam int NUM_EVT = 6;
  // event bit positions, shared by evt_i, enable and status
  localparam int EVT_TIMEOUT = 0;
  localparam int EVT_DROP    = 1;
  localparam int EVT_HALF    = 2;
  localparam int EVT_FRAME   = 3;
  localparam int EVT_LAST    = 4;
  localparam int EVT_BLOCK   = 5;
  localparam int SYNC_BIT    = NUM_EVT;
  localparam logic [NUM_EVT-1:0] EN_RST =
    NUM_EVT'((1 << EVT_DROP) | (1 << EVT_TIMEOUT));
endpackage

// File: rtl/dma_irq_en_reg.sv
module dma_irq_en_reg #(
  parameter int                 NUM_EVT = 6,
  parameter logic [NUM_EVT-1:0] RST_VAL = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [NUM_EVT-1:0] wdata_i,
  output logic [NUM_EVT-1:0] en_o
);
  logic [NUM_EVT-1:0] en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_q <= RST_VAL;
    else if (we_i) en_q <= wdata_i;
  end

  assign en_o = en_q;

  // R2: enables only move on a write
  a_r2_en_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(en_q));
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int NUM_EVT = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] en_i,
  input  logic               clr_i,
  output logic [NUM_EVT-1:0] status_o
);
  logic [NUM_EVT-1:0] st_q;

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_bit
    logic set_w;
    assign set_w = evt_i[k] & en_i[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[k] <= 1'b0;
      else         st_q[k] <= set_w | (st_q[k] & ~clr_i);
    end

    // R3: enabled event is recorded
    a_r3_enabled_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[k] && en_i[k]) |=> st_q[k]);
    // R4: disabled event never sets a clear bit
    a_r4_disabled_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!en_i[k] && !st_q[k]) |=> !st_q[k]);
    // R8: set bit survives until a clearing read
    a_r8_bit_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[k] && !clr_i) |=> st_q[k]);
    // R5: clearing read empties the bit unless an event coincides (R6)
    a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !(evt_i[k] && en_i[k])) |=> !st_q[k]);
  end

  assign status_o = st_q;
endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq
  import dma_irq_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               sync_pend_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               we_i,
  input  logic               re_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  output logic               irq_o
);
  localparam logic [ADDR_W-1:0] ADDR_EN = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_ST = ADDR_W'(1);

  logic [NUM_EVT-1:0] en_w, st_w;
  logic               en_we_w, rd_clr_w;
  logic [REG_W-1:0]   rdata_q;
  logic               unused_wdata;

  assign en_we_w      = we_i && (addr_i == ADDR_EN);
  assign rd_clr_w     = re_i && (addr_i == ADDR_ST);
  assign unused_wdata = ^wdata_i[REG_W-1:NUM_EVT];

  dma_irq_en_reg #(
    .NUM_EVT (NUM_EVT),
    .RST_VAL (EN_RST)
  ) i_en_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (en_we_w),
    .wdata_i (wdata_i[NUM_EVT-1:0]),
    .en_o    (en_w)
  );

  dma_irq_status #(
    .NUM_EVT (NUM_EVT)
  ) i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .en_i     (en_w),
    .clr_i    (rd_clr_w),
    .status_o (st_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (re_i) begin
      unique case (addr_i)
        ADDR_EN: rdata_q <= REG_W'(en_w);
        ADDR_ST: rdata_q <= REG_W'({sync_pend_i, st_w});
        default: rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |st_w;

  // R7: request stays up until a clearing read
  a_r7_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !rd_clr_w) |=> irq_o);
  // R11: read data holds between reads
  a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: tb/test_dma_chan_irq.sv
module test_dma_chan_irq;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] A_EN = 2'd0;
  localparam logic [1:0] A_ST = 2'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  evt = '0;
  logic        sync_pend = 1'b0;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic [15:0] exp_q[$];
  string       req_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_irq i_dma_chan_irq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .evt_i       (evt),
    .sync_pend_i (sync_pend),
    .addr_i      (addr),
    .we_i        (we),
    .re_i        (re),
    .wdata_i     (wdata),
    .rdata_o     (rdata),
    .irq_o       (irq)
  );

  // monitor: compare read data a quarter period after the capturing edge
  always @(posedge clk) begin
    if (re && rst_n) begin
      #(CLK_PERIOD/4);
      if (exp_q.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL %s: unexpected read, actual %h expected none", "R11", rdata);
      end else begin
        logic [15:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        n_checks++;
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: rdata actual %h expected %h", r, rdata, e);
        end
      end
    end
  end

  task automatic rd(input logic [1:0] a, input logic [15:0] e, input string r);
    addr = a; re = 1'b1;
    exp_q.push_back(e); req_q.push_back(r);
    @(negedge clk);
    re = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] m);
    evt = m;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic chk_irq(input logic e, input string r);
    n_checks++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq actual %b expected %b", r, irq, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(A_EN, 16'h0003, "R1");
    rd(A_ST, 16'h0000, "R1");
    // R4 block event disabled by default
    pulse(6'b100000);
    chk_irq(1'b0, "R4");
    rd(A_ST, 16'h0000, "R4");
    // R2 reserved bits dropped
    wr(A_EN, 16'hFFFF);
    rd(A_EN, 16'h003F, "R2");
    // R3 block event, then R5 clear
    pulse(6'b100000);
    chk_irq(1'b0 ^ 1'b1, "R3");
    rd(A_ST, 16'h0020, "R3");
    chk_irq(1'b0, "R5");
    rd(A_ST, 16'h0000, "R5");
    // R3 each bit position
    for (int k = 0; k < 6; k++) begin
      pulse(6'(1 << k));
      rd(A_ST, 16'(1 << k), "R3");
    end
    // R7 irq held until read
    pulse(6'b000100);
    repeat (5) @(negedge clk);
    chk_irq(1'b1, "R7");
    rd(A_ST, 16'h0004, "R7");
    chk_irq(1'b0, "R7");
    // R8 disabling keeps recorded bit
    pulse(6'b001000);
    wr(A_EN, 16'h0000);
    chk_irq(1'b1, "R8");
    rd(A_ST, 16'h0008, "R8");
    // R4 all disabled
    pulse(6'b111111);
    chk_irq(1'b0, "R4");
    rd(A_ST, 16'h0000, "R4");
    // R9 status writes do nothing
    wr(A_EN, 16'h0002);
    wr(A_ST, 16'hFFFF);
    chk_irq(1'b0, "R9");
    rd(A_ST, 16'h0000, "R9");
    pulse(6'b000010);
    wr(A_ST, 16'h0000);
    chk_irq(1'b1, "R9");
    rd(A_ST, 16'h0002, "R9");
    // R6 event coinciding with a clearing read
    wr(A_EN, 16'h003F);
    pulse(6'b000001);
    evt = 6'b010000;
    rd(A_ST, 16'h0001, "R6");
    evt = '0;
    chk_irq(1'b1, "R6");
    rd(A_ST, 16'h0010, "R6");
    // R10 sync mirror, not cleared, no irq
    sync_pend = 1'b1;
    rd(A_ST, 16'h0040, "R10");
    chk_irq(1'b0, "R10");
    rd(A_ST, 16'h0040, "R10");
    sync_pend = 1'b0;
    rd(A_ST, 16'h0000, "R10");
    // R11 unmapped address reads zero
    rd(2'd2, 16'h0000, "R11");
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule